// File: doc/BRIEF.md
# Decoded Micro-op Way Packer

This block sits on the fill path of a decoded micro-op cache. Each cycle it can accept one decoded instruction. The instruction carries its start address, its byte length, its micro-op count, a branch kind, a fusion flag, and a predicted-taken flag with a target address. The block packs the micro-ops of these instructions into way-sized fill records, and each record belongs to one naturally aligned 32-byte code region.

A region stays open while instructions keep arriving inside it. When the first instruction from a different region arrives, the block commits the old region. It either presents all of that region's ways at once on a lane bus, or it raises a single uncacheable flag carrying the region tag. In the uncacheable case no records for that region appear.

A way closes early in these cases:
- after an unconditional control transfer;
- after a predicted-taken branch that stays inside the region;
- at an address discontinuity;
- when the next instruction's micro-ops do not fit in the way.

A region is rejected in these cases:
- a control transfer touches the region's last byte or crosses the region's end;
- an instruction has more micro-ops than a way holds;
- the region would need more ways than allowed.

Top module: `upk_way_packer`

## Requirements
- R1: A way holds at most 6 micro-ops, and one instruction's micro-ops are never split. If an instruction does not fit in the open way, that way closes and a new way starts at the instruction's offset.
- R2: A region is committed when an instruction from another region (address bits [31:5]) is accepted. In the following cycle, lanes 0..n-1 of `rec_valid_o` are set in way order, `rec_tag_o` carries the region tag, and each lane carries the byte offset (address bits [4:0]) of the way's first instruction and its slot count. No output is produced in any other cycle.
- R3: A region that would need a fourth way is committed as uncacheable.
- R4: Kinds 2 (direct jump), 3 (indirect jump), 4 (direct call), 5 (indirect call) and 6 (return) end the open way after their own micro-ops.
- R5: A predicted-taken instruction whose target lies in the same region ends the way. A taken target in another region, or a not-taken kind 1 (conditional), does not end the way.
- R6: An instruction of kinds 1 to 6 with offset + length >= 32 makes its region uncacheable. Kind 0 (no branch) and kind 7 never trigger this rule.
- R7: When `ins_fused_i` is set, the entry (address of the leading instruction, combined length) occupies exactly one slot, whatever `ins_uops_i` says.
- R8: Inside a region, an instruction whose address differs from the previous address + length closes the open way. The region itself continues.
- R9: An uncacheable commit pulses `unc_o` for one cycle with `unc_tag_o` and no record lanes. Instructions of a region are ignored once it has been rejected.
- R10: An instruction with more than 6 micro-ops (`ins_uops_i` = 7) makes its region uncacheable.
- R11: After reset no region is open and all strobes are low. The first instruction produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ins_valid_i | input | 1 | Instruction present this cycle |
| ins_addr_i | input | ADDR_W | Start address (leading instruction when fused) |
| ins_len_i | input | LEN_W | Byte length, 1..15 |
| ins_uops_i | input | UOP_W | Micro-op count, 1..7 |
| ins_kind_i | input | 3 | Branch kind: 0 none, 1 conditional, 2 jump, 3 indirect jump, 4 call, 5 indirect call, 6 return |
| ins_fused_i | input | 1 | Compare-and-branch pair presented as one entry |
| ins_taken_i | input | 1 | Predicted taken |
| ins_target_i | input | ADDR_W | Predicted target |
| rec_valid_o | output | MAX_WAYS | Record strobe per lane; lane index is the way number |
| rec_tag_o | output | ADDR_W-5 | Region tag of the records |
| rec_off_o | output | MAX_WAYS*5 | Starting byte offset per lane |
| rec_slots_o | output | MAX_WAYS*3 | Slot count per lane |
| unc_o | output | 1 | Region-uncacheable pulse |
| unc_tag_o | output | ADDR_W-5 | Tag of the rejected region |

## Verification
The bound checker enforces four properties on every cycle:
- lanes fill from lane 0 upward;
- every emitted lane holds between one and six slots;
- the uncacheable pulse never coincides with a record;
- any output follows an accepted instruction.

Only the bench's scenarios can show where ways actually break and whether a region is rejected. That covers:
- jumps ending on byte 31 versus byte 30;
- a fused pair counted once;
- taken branches inside versus outside the region;
- a looped body that needs a fourth way;
- a long randomized stream compared against a queue-based model.

// File: rtl/upk_pkg.sv
package upk_pkg;
  typedef enum logic [2:0] {
    BK_NONE     = 3'd0,
    BK_COND     = 3'd1,
    BK_JMP      = 3'd2,
    BK_JMP_IND  = 3'd3,
    BK_CALL     = 3'd4,
    BK_CALL_IND = 3'd5,
    BK_RET      = 3'd6,
    BK_RSVD     = 3'd7
  } br_kind_e;

  function automatic logic is_xfer(br_kind_e k);
    return (k != BK_NONE) && (k != BK_RSVD);
  endfunction

  function automatic logic is_uncond(br_kind_e k);
    return is_xfer(k) && (k != BK_COND);
  endfunction
endpackage

// File: rtl/upk_classify.sv
module upk_classify import upk_pkg::*; #(
  parameter int ADDR_W    = 32,
  parameter int REGION_B  = 5,
  parameter int LEN_W     = 4,
  parameter int UOP_W     = 3,
  parameter int WAY_SLOTS = 6,
  localparam int TAG_W    = ADDR_W - REGION_B
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic [UOP_W-1:0]    uops_i,
  input  logic [2:0]          kind_i,
  input  logic                fused_i,
  input  logic                taken_i,
  input  logic [ADDR_W-1:0]   target_i,
  output logic [TAG_W-1:0]    tag_o,
  output logic [REGION_B-1:0] off_o,
  output logic [UOP_W-1:0]    uops_o,
  output logic                reject_o,
  output logic                ends_way_o
);
  br_kind_e          kind;
  logic [REGION_B:0] end_sum;
  logic              unused_tgt;

  assign kind    = br_kind_e'(kind_i);
  assign tag_o   = addr_i[ADDR_W-1:REGION_B];
  assign off_o   = addr_i[REGION_B-1:0];
  assign uops_o  = fused_i ? UOP_W'(1) : uops_i;
  // carry out of the region offset: last byte at or past region end
  assign end_sum = {1'b0, off_o} + (REGION_B+1)'(len_i);

  assign reject_o   = (is_xfer(kind) && end_sum[REGION_B]) ||
                      (uops_o > UOP_W'(WAY_SLOTS));
  assign ends_way_o = is_uncond(kind) ||
                      (taken_i && (target_i[ADDR_W-1:REGION_B] == tag_o));
  assign unused_tgt = ^target_i[REGION_B-1:0];
endmodule

// File: rtl/upk_region_buf.sv
module upk_region_buf #(
  parameter int ADDR_W    = 32,
  parameter int REGION_B  = 5,
  parameter int LEN_W     = 4,
  parameter int UOP_W     = 3,
  parameter int WAY_SLOTS = 6,
  parameter int MAX_WAYS  = 3,
  localparam int TAG_W    = ADDR_W - REGION_B,
  localparam int SLOT_W   = $clog2(WAY_SLOTS + 1)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         in_v_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [LEN_W-1:0]             len_i,
  input  logic [TAG_W-1:0]             tag_i,
  input  logic [REGION_B-1:0]          off_i,
  input  logic [UOP_W-1:0]             uops_i,
  input  logic                         reject_i,
  input  logic                         ends_way_i,
  output logic [MAX_WAYS-1:0]          rec_valid_o,
  output logic [TAG_W-1:0]             rec_tag_o,
  output logic [MAX_WAYS*REGION_B-1:0] rec_off_o,
  output logic [MAX_WAYS*SLOT_W-1:0]   rec_slots_o,
  output logic                         unc_o,
  output logic [TAG_W-1:0]             unc_tag_o
);
  localparam int CNT_W = $clog2(MAX_WAYS + 1);
  localparam int SUM_W = ((SLOT_W > UOP_W) ? SLOT_W : UOP_W) + 1;

  logic                active_q, n_active, poison_q, n_poison, open_q, n_open;
  logic [TAG_W-1:0]    tag_q, n_tag;
  logic [CNT_W-1:0]    cnt_q, n_cnt;
  logic [REGION_B-1:0] ooff_q, n_ooff;
  logic [SLOT_W-1:0]   oslots_q, n_oslots;
  logic [ADDR_W-1:0]   exp_q, n_exp;
  logic [REGION_B-1:0] way_off_q [MAX_WAYS];
  logic [REGION_B-1:0] n_way_off [MAX_WAYS];
  logic [SLOT_W-1:0]   way_slots_q [MAX_WAYS];
  logic [SLOT_W-1:0]   n_way_slots [MAX_WAYS];

  logic [MAX_WAYS-1:0]          n_rv;
  logic [TAG_W-1:0]             n_rtag, n_utag;
  logic [MAX_WAYS*REGION_B-1:0] n_roff;
  logic [MAX_WAYS*SLOT_W-1:0]   n_rslots;
  logic                         n_unc, new_reg, disc;

  always_comb begin
    n_active = active_q;  n_poison = poison_q;  n_open = open_q;
    n_tag = tag_q;  n_cnt = cnt_q;  n_ooff = ooff_q;  n_oslots = oslots_q;
    n_exp = exp_q;  n_way_off = way_off_q;  n_way_slots = way_slots_q;
    n_rv = '0;  n_rtag = rec_tag_o;  n_roff = '0;  n_rslots = '0;
    n_unc = 1'b0;  n_utag = unc_tag_o;
    new_reg = 1'b0;  disc = 1'b0;
    if (in_v_i) begin
      new_reg = !active_q || (tag_i != tag_q);
      if (new_reg) begin
        if (active_q && poison_q) begin
          n_unc  = 1'b1;
          n_utag = tag_q;
        end else if (active_q) begin
          n_rtag = tag_q;
          for (int i = 0; i < MAX_WAYS; i++) begin
            if (CNT_W'(i) < cnt_q) begin
              n_rv[i] = 1'b1;
              n_roff[i*REGION_B +: REGION_B] = way_off_q[i];
              n_rslots[i*SLOT_W +: SLOT_W]   = way_slots_q[i];
            end else if (CNT_W'(i) == cnt_q && open_q) begin
              n_rv[i] = 1'b1;
              n_roff[i*REGION_B +: REGION_B] = ooff_q;
              n_rslots[i*SLOT_W +: SLOT_W]   = oslots_q;
            end
          end
        end
        n_active = 1'b1;  n_tag = tag_i;  n_poison = 1'b0;
        n_cnt = '0;  n_open = 1'b0;
      end else begin
        disc = (addr_i != exp_q);
      end
      if (!n_poison) begin
        if (reject_i) begin
          n_poison = 1'b1;
        end else begin
          // close before: gap in the stream or no room for the whole instruction
          if (n_open && (disc || (SUM_W'(n_oslots) + SUM_W'(uops_i) > SUM_W'(WAY_SLOTS)))) begin
            for (int i = 0; i < MAX_WAYS; i++)
              if (CNT_W'(i) == n_cnt) begin
                n_way_off[i] = n_ooff;  n_way_slots[i] = n_oslots;
              end
            n_cnt  = n_cnt + CNT_W'(1);
            n_open = 1'b0;
          end
          if (!n_open) begin
            if (n_cnt == CNT_W'(MAX_WAYS)) n_poison = 1'b1;
            else begin
              n_open = 1'b1;  n_ooff = off_i;  n_oslots = '0;
            end
          end
          if (!n_poison) begin
            n_oslots = n_oslots + SLOT_W'(uops_i);
            if (ends_way_i) begin
              for (int i = 0; i < MAX_WAYS; i++)
                if (CNT_W'(i) == n_cnt) begin
                  n_way_off[i] = n_ooff;  n_way_slots[i] = n_oslots;
                end
              n_cnt  = n_cnt + CNT_W'(1);
              n_open = 1'b0;
            end
          end
        end
      end
      n_exp = addr_i + ADDR_W'(len_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;  poison_q <= 1'b0;  open_q <= 1'b0;
      tag_q <= '0;  cnt_q <= '0;  ooff_q <= '0;  oslots_q <= '0;  exp_q <= '0;
      for (int i = 0; i < MAX_WAYS; i++) begin
        way_off_q[i] <= '0;  way_slots_q[i] <= '0;
      end
      rec_valid_o <= '0;  rec_tag_o <= '0;  rec_off_o <= '0;  rec_slots_o <= '0;
      unc_o <= 1'b0;  unc_tag_o <= '0;
    end else begin
      active_q <= n_active;  poison_q <= n_poison;  open_q <= n_open;
      tag_q <= n_tag;  cnt_q <= n_cnt;  ooff_q <= n_ooff;  oslots_q <= n_oslots;
      exp_q <= n_exp;  way_off_q <= n_way_off;  way_slots_q <= n_way_slots;
      rec_valid_o <= n_rv;  rec_tag_o <= n_rtag;  rec_off_o <= n_roff;
      rec_slots_o <= n_rslots;  unc_o <= n_unc;  unc_tag_o <= n_utag;
    end
  end
endmodule

// File: rtl/upk_way_packer.sv
module upk_way_packer import upk_pkg::*; #(
  parameter int ADDR_W    = 32,
  parameter int REGION_B  = 5,
  parameter int LEN_W     = 4,
  parameter int UOP_W     = 3,
  parameter int WAY_SLOTS = 6,
  parameter int MAX_WAYS  = 3,
  localparam int TAG_W    = ADDR_W - REGION_B,
  localparam int SLOT_W   = $clog2(WAY_SLOTS + 1)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         ins_valid_i,
  input  logic [ADDR_W-1:0]            ins_addr_i,
  input  logic [LEN_W-1:0]             ins_len_i,
  input  logic [UOP_W-1:0]             ins_uops_i,
  input  logic [2:0]                   ins_kind_i,
  input  logic                         ins_fused_i,
  input  logic                         ins_taken_i,
  input  logic [ADDR_W-1:0]            ins_target_i,
  output logic [MAX_WAYS-1:0]          rec_valid_o,
  output logic [TAG_W-1:0]             rec_tag_o,
  output logic [MAX_WAYS*REGION_B-1:0] rec_off_o,
  output logic [MAX_WAYS*SLOT_W-1:0]   rec_slots_o,
  output logic                         unc_o,
  output logic [TAG_W-1:0]             unc_tag_o
);
  logic [TAG_W-1:0]    c_tag;
  logic [REGION_B-1:0] c_off;
  logic [UOP_W-1:0]    c_uops;
  logic                c_reject, c_ends;

  upk_classify #(
    .ADDR_W(ADDR_W), .REGION_B(REGION_B), .LEN_W(LEN_W),
    .UOP_W(UOP_W), .WAY_SLOTS(WAY_SLOTS)
  ) u_cls (
    .addr_i(ins_addr_i), .len_i(ins_len_i), .uops_i(ins_uops_i),
    .kind_i(ins_kind_i), .fused_i(ins_fused_i), .taken_i(ins_taken_i),
    .target_i(ins_target_i), .tag_o(c_tag), .off_o(c_off), .uops_o(c_uops),
    .reject_o(c_reject), .ends_way_o(c_ends)
  );

  upk_region_buf #(
    .ADDR_W(ADDR_W), .REGION_B(REGION_B), .LEN_W(LEN_W), .UOP_W(UOP_W),
    .WAY_SLOTS(WAY_SLOTS), .MAX_WAYS(MAX_WAYS)
  ) u_buf (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_v_i(ins_valid_i),
    .addr_i(ins_addr_i), .len_i(ins_len_i), .tag_i(c_tag), .off_i(c_off),
    .uops_i(c_uops), .reject_i(c_reject), .ends_way_i(c_ends),
    .rec_valid_o(rec_valid_o), .rec_tag_o(rec_tag_o), .rec_off_o(rec_off_o),
    .rec_slots_o(rec_slots_o), .unc_o(unc_o), .unc_tag_o(unc_tag_o)
  );
endmodule

// File: rtl/upk_checker.sv
module upk_checker #(
  parameter int MAX_WAYS  = 3,
  parameter int WAY_SLOTS = 6,
  parameter int SLOT_W    = 3
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       ins_valid_i,
  input logic [MAX_WAYS-1:0]        rec_valid_o,
  input logic [MAX_WAYS*SLOT_W-1:0] rec_slots_o,
  input logic                       unc_o
);
  for (genvar i = 0; i < MAX_WAYS; i++) begin : g_lane
    p_slot_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rec_valid_o[i] |-> (rec_slots_o[i*SLOT_W +: SLOT_W] != '0) &&
                         (rec_slots_o[i*SLOT_W +: SLOT_W] <= SLOT_W'(WAY_SLOTS)));
    if (i > 0) begin : g_ord
      p_lane_order_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rec_valid_o[i] |-> rec_valid_o[i-1]);
    end
  end

  p_unc_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unc_o |-> (rec_valid_o == '0));

  p_event_cause_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unc_o || (|rec_valid_o)) |-> $past(ins_valid_i));
endmodule

bind upk_way_packer upk_checker #(
  .MAX_WAYS(MAX_WAYS), .WAY_SLOTS(WAY_SLOTS), .SLOT_W(SLOT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ins_valid_i(ins_valid_i),
  .rec_valid_o(rec_valid_o), .rec_slots_o(rec_slots_o), .unc_o(unc_o)
);

// File: tb/tb_upk_way_packer.sv
`timescale 1ns/1ps
module tb_upk_way_packer;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        ins_valid = 1'b0, ins_fused = 1'b0, ins_taken = 1'b0;
  logic [31:0] ins_addr = '0, ins_target = '0;
  logic [3:0]  ins_len = '0;
  logic [2:0]  ins_uops = '0, ins_kind = '0;
  logic [2:0]  rec_valid;
  logic [26:0] rec_tag, unc_tag;
  logic [14:0] rec_off;
  logic [8:0]  rec_slots;
  logic        unc;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  upk_way_packer dut (
    .clk_i(clk), .rst_ni(rst_n), .ins_valid_i(ins_valid), .ins_addr_i(ins_addr),
    .ins_len_i(ins_len), .ins_uops_i(ins_uops), .ins_kind_i(ins_kind),
    .ins_fused_i(ins_fused), .ins_taken_i(ins_taken), .ins_target_i(ins_target),
    .rec_valid_o(rec_valid), .rec_tag_o(rec_tag), .rec_off_o(rec_off),
    .rec_slots_o(rec_slots), .unc_o(unc), .unc_tag_o(unc_tag)
  );

  // reference model state
  bit        m_active = 0, m_poison = 0, m_open = 0;
  bit [26:0] m_tag;
  int        m_ooff, m_oslots;
  bit [31:0] m_exp;
  int        q_off[$], q_slots[$];
  // expected outputs: next cycle and current cycle
  bit [2:0]  nx_v = '0, ex_v;
  int        nx_off[3], nx_slots[3], ex_off[3], ex_slots[3];
  bit [26:0] nx_tag, nx_utag, ex_tag, ex_utag;
  bit        nx_unc = 0, ex_unc;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic void model(bit [31:0] a, int ln, int up, int kd, bit fu, bit tk, bit [31:0] tg);
    bit [26:0] rt = a[31:5];
    int  off = int'(a[4:0]);
    int  eu = fu ? 1 : up;
    bit  jmp = (kd >= 1 && kd <= 6);
    bit  ucd = (kd >= 2 && kd <= 6);
    bit  disc = 0;
    if (!m_active || rt != m_tag) begin
      if (m_active && m_poison) begin
        nx_unc = 1; nx_utag = m_tag;
      end else if (m_active) begin
        nx_tag = m_tag;
        foreach (q_off[i]) begin nx_v[i] = 1; nx_off[i] = q_off[i]; nx_slots[i] = q_slots[i]; end
        if (m_open) begin
          nx_v[q_off.size()] = 1; nx_off[q_off.size()] = m_ooff; nx_slots[q_off.size()] = m_oslots;
        end
      end
      m_active = 1; m_tag = rt; m_poison = 0; m_open = 0;
      q_off.delete(); q_slots.delete();
    end else disc = (a != m_exp);
    if (!m_poison) begin
      if ((jmp && off + ln >= 32) || eu > 6) m_poison = 1;
      else begin
        if (m_open && (disc || m_oslots + eu > 6)) begin
          q_off.push_back(m_ooff); q_slots.push_back(m_oslots); m_open = 0;
        end
        if (!m_open) begin
          if (q_off.size() == 3) m_poison = 1;
          else begin m_open = 1; m_ooff = off; m_oslots = 0; end
        end
        if (!m_poison) begin
          m_oslots += eu;
          if (ucd || (tk && tg[31:5] == rt)) begin
            q_off.push_back(m_ooff); q_slots.push_back(m_oslots); m_open = 0;
          end
        end
      end
    end
    m_exp = a + ln;
  endfunction

  task automatic send(input bit [31:0] a, input int ln, input int up, input int kd,
                      input bit fu = 0, input bit tk = 0, input bit [31:0] tg = 0);
    @(negedge clk);
    ins_valid = 1; ins_addr = a; ins_len = 4'(ln); ins_uops = 3'(up);
    ins_kind = 3'(kd); ins_fused = fu; ins_taken = tk; ins_target = tg;
    model(a, ln, up, kd, fu, tk, tg);
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); ins_valid = 0; end
  endtask

  task automatic settle;
    @(posedge clk); #1;
  endtask

  // cycle-by-cycle comparison against the model
  always @(posedge clk) begin
    ex_v = nx_v; ex_off = nx_off; ex_slots = nx_slots; ex_tag = nx_tag;
    ex_unc = nx_unc; ex_utag = nx_utag;
    nx_v = '0; nx_unc = 0;
    #1;
    if (rst_n) begin
      chk("R2", "rec_valid", rec_valid, ex_v);
      if (ex_v != 0) chk("R2", "rec_tag", rec_tag, ex_tag);
      for (int i = 0; i < 3; i++)
        if (ex_v[i]) begin
          chk("R2", "lane offset", rec_off[i*5 +: 5], ex_off[i]);
          chk("R1", "lane slots", rec_slots[i*3 +: 3], ex_slots[i]);
        end
      chk("R9", "unc", unc, ex_unc);
      if (ex_unc) chk("R9", "unc_tag", unc_tag, ex_utag);
    end
  end

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R11 watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R11", "reset rec_valid", rec_valid, 0);
    chk("R11", "reset unc", unc, 0);
    @(negedge clk); rst_n = 1;

    // R4/R5: five moves + jump fill one way; dec + taken in-region branch form the next
    send(32'h1000, 2, 1, 0);
    settle();
    chk("R11", "first instr rec_valid", rec_valid, 0);
    chk("R11", "first instr unc", unc, 0);
    for (int k = 1; k < 5; k++) send(32'h1000 + 2*k, 2, 1, 0);
    send(32'h100a, 2, 1, 2, 0, 1, 32'h100c);
    send(32'h100c, 3, 1, 0);
    send(32'h100f, 2, 1, 1, 0, 1, 32'h1000);
    send(32'h2000, 2, 1, 0);
    settle();
    chk("R2", "S1 lanes", rec_valid, 3'b011);
    chk("R2", "S1 tag", rec_tag, 27'h80);
    chk("R4", "S1 lane0 slots", rec_slots[2:0], 6);
    chk("R5", "S1 lane1 off", rec_off[9:5], 12);
    chk("R5", "S1 lane1 slots", rec_slots[5:3], 2);

    // R1: six moves then a jump that no longer fits
    for (int k = 1; k < 6; k++) send(32'h2000 + 2*k, 2, 1, 0);
    send(32'h200c, 2, 1, 2, 0, 1, 32'h200e);
    send(32'h200e, 3, 1, 0);
    send(32'h2011, 2, 1, 1, 0, 1, 32'h2000);
    send(32'h3000, 2, 1, 0);
    settle();
    chk("R1", "S2 lanes", rec_valid, 3'b111);
    chk("R1", "S2 lane0 slots", rec_slots[2:0], 6);
    chk("R1", "S2 lane1 off", rec_off[9:5], 12);
    chk("R1", "S2 lane1 slots", rec_slots[5:3], 1);
    chk("R1", "S2 lane2 off", rec_off[14:10], 14);

    // R3: same body, then loop back needs a fourth way
    for (int k = 1; k < 6; k++) send(32'h3000 + 2*k, 2, 1, 0);
    send(32'h300c, 2, 1, 2, 0, 1, 32'h300e);
    send(32'h300e, 3, 1, 0);
    send(32'h3011, 2, 1, 1, 0, 1, 32'h3000);
    send(32'h3000, 2, 1, 0);
    send(32'h3002, 2, 1, 0);
    send(32'h4000, 2, 1, 0);
    settle();
    chk("R3", "S3 unc", unc, 1);
    chk("R3", "S3 unc tag", unc_tag, 27'h180);
    chk("R9", "S3 no lanes", rec_valid, 0);

    // R6: conditional ending on byte 30 and a plain instruction crossing are fine
    send(32'h4002, 14, 1, 0);
    send(32'h4010, 13, 1, 0);
    send(32'h401d, 2, 1, 1);
    send(32'h401f, 3, 1, 0);
    send(32'h4022, 2, 1, 0);
    settle();
    chk("R6", "S4 lanes", rec_valid, 3'b001);
    chk("R6", "S4 slots", rec_slots[2:0], 5);
    chk("R6", "S4 tag", rec_tag, 27'h200);
    // conditional ending on the region's last byte
    send(32'h4024, 15, 1, 0);
    send(32'h4033, 11, 1, 0);
    send(32'h403e, 2, 1, 1);
    send(32'h5000, 2, 1, 0);
    settle();
    chk("R6", "S4 boundary unc", unc, 1);
    chk("R6", "S4 boundary tag", unc_tag, 27'h201);

    // R7/R5/R8: fused pair, taken out of region, gap, overflow
    send(32'h5002, 5, 2, 1, 1, 1, 32'h9000);
    send(32'h5007, 2, 1, 0);
    send(32'h5010, 2, 1, 0);
    send(32'h5012, 2, 4, 0);
    send(32'h5014, 2, 2, 0);
    send(32'h6000, 2, 1, 0);
    settle();
    chk("R8", "S5 lanes", rec_valid, 3'b111);
    chk("R7", "S5 lane0 slots", rec_slots[2:0], 3);
    chk("R8", "S5 lane1 off", rec_off[9:5], 16);
    chk("R1", "S5 lane1 slots", rec_slots[5:3], 5);
    chk("R1", "S5 lane2 off", rec_off[14:10], 20);

    // R10 and R9: oversize instruction, later instructions ignored
    send(32'h6002, 3, 7, 0);
    send(32'h6005, 2, 1, 0);
    send(32'h6007, 2, 1, 2);
    idle(2);
    send(32'h7000, 2, 1, 0);
    settle();
    chk("R10", "S6 unc", unc, 1);
    chk("R9", "S6 unc tag", unc_tag, 27'h300);
    chk("R9", "S6 no lanes", rec_valid, 0);

    // randomized stream, checked every cycle against the model
    begin
      bit [31:0] pc = 32'h0001_0000;
      for (int k = 0; k < 3000; k++) begin
        int ln = $urandom_range(15, 1);
        int up = ($urandom_range(39, 0) == 0) ? 7 : $urandom_range(6, 1);
        int kd = ($urandom_range(9, 0) < 6) ? 0 : $urandom_range(7, 1);
        bit fu = (kd == 1) && ($urandom_range(3, 0) == 0);
        bit tk = (kd >= 2 && kd <= 6) ? 1'b1 : ((kd == 1) ? 1'($urandom_range(1, 0)) : 1'b0);
        bit [31:0] tg = ($urandom_range(1, 0) == 1) ? {pc[31:5], 5'($urandom_range(31, 0))}
                                                    : pc + 32'($urandom_range(200, 40));
        send(pc, ln, up, kd, fu, tk, tg);
        pc = tk ? tg : pc + 32'(ln);
        if ($urandom_range(15, 0) == 0) idle(1);
      end
    end
    send(32'h00F0_0000, 2, 1, 0);
    idle(4);
    done = 1;
    summary();
    $finish;
  end
endmodule